// File: doc/BRIEF.md
# Circular Interrupt Queue Controller

This block records per-channel exceptions as entries in five circular tables held in a small internal memory. Queues 0 to 3 take receive events and queue 4 takes transmit events. Each queue has its own write position. An entry is written with its valid flag set. While that flag stays set, the slot counts as owned by the host. When a write lands on an owned slot, the block drops the entry and reports an overflow for that queue.

A 16-bit event register gathers these conditions: overflow and new-entry bits for each queue, plus global transmit underrun and receive overrun strobes. A mask register uses the same layout. The interrupt request is raised whenever an event bit and its mask bit are both set. The host works through a queue as follows:
- It reads entries in order from its own read position.
- It clears each entry's valid flag through the entry-clear port.
- It stops at the first entry whose flag is clear.
- It acknowledges event bits by writing ones to them.

Top module: `irq_queue_ctrl`

## Requirements
- R1: A post to a queue whose slot at the current write position has bit 31 clear writes that slot. Bit 31 becomes 1, bits 23:16 hold the channel, bits 7:0 hold the code, and all other bits are zero. The word is readable through the entry read port (queue number 0-3 receive, 4 transmit; slot index) from the following cycle.
- R2: After a successful write, the queue's write position advances by one and wraps from slot QDEPTH-1 to slot 0.
- R3: A post that targets a slot with bit 31 still set leaves the slot unchanged and keeps the write position. It sets the queue's overflow event: bit 2n for receive queue n, bit 12 for the transmit queue.
- R4: A successful post sets the queue's new-entry event: bit 2n+1 for receive queue n, bit 13 for the transmit queue. Receive posts never write the transmit queue, and transmit posts never write a receive queue.
- R5: A pulse on the underrun strobe sets event bit 14, and a pulse on the overrun strobe sets bit 15. Both stay set until software clears them.
- R6: Event bits are sticky. A register write with reg_sel=0 clears the bits where reg_wdata is 1 and leaves the other bits alone. A bit that is set in the same cycle as its clear stays set.
- R7: A register write with reg_sel=1 loads the mask, which uses the event layout. Bits 11:8 of both the mask and the event register always read zero.
- R8: irq is high exactly when some event bit and the same mask bit are both 1. It follows the registers with no further delay.
- R9: ent_clr clears bit 31 of the addressed slot. A post to that slot in the same cycle still sees the slot as owned and overflows.
- R10: A receive post and a transmit post in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_post_vld | input | 1 | Receive entry post strobe |
| rx_post_q | input | 2 | Target receive queue |
| rx_post_chan | input | 8 | Channel number of the receive entry |
| rx_post_code | input | 8 | Event code of the receive entry |
| tx_post_vld | input | 1 | Transmit entry post strobe |
| tx_post_chan | input | 8 | Channel number of the transmit entry |
| tx_post_code | input | 8 | Event code of the transmit entry |
| gun_strobe | input | 1 | Global transmit underrun pulse |
| gov_strobe | input | 1 | Global receive overrun pulse |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 1 | 0 selects event write-one-to-clear, 1 selects mask load |
| reg_wdata | input | 16 | Host register write data |
| evt_status | output | 16 | Event register contents |
| mask_status | output | 16 | Mask register contents |
| ent_clr | input | 1 | Clear the valid flag of one entry |
| ent_clr_q | input | 3 | Queue of the entry to clear |
| ent_clr_idx | input | 3 | Slot of the entry to clear |
| ent_rd_q | input | 3 | Queue of the entry to read |
| ent_rd_idx | input | 3 | Slot of the entry to read |
| ent_rd_data | output | 32 | Addressed entry word |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of actions can fall in the same clock. The first pair is the host acknowledging an event bit while a post sets that same bit. The bench holds a write-one-to-clear of the new-entry bit in the cycle of a post to that queue, and it expects the bit to read back as set afterwards. The second pair is freeing a slot while a post targets it. The bench fills a queue until the write position returns to an owned slot, then drives the entry clear and the post together. It expects an overflow bit, a cleared valid flag in that slot, and a later post that lands there.

// File: rtl/irqq_pkg.sv
package irqq_pkg;

    localparam int NUM_RXQ  = 4;
    localparam int NUM_Q    = NUM_RXQ + 1;
    localparam int TXQ_ID   = NUM_RXQ;
    localparam int CHAN_W   = 8;
    localparam int CODE_W   = 8;
    localparam int ENTRY_W  = 32;
    localparam int EVT_W    = 16;

    localparam int TQOV_BIT = 12;
    localparam int TINT_BIT = 13;
    localparam int GUN_BIT  = 14;
    localparam int GOV_BIT  = 15;

    localparam logic [EVT_W-1:0] EVT_USED = 16'hF0FF;

    typedef enum logic {
        SEL_EVT  = 1'b0,
        SEL_MASK = 1'b1
    } regsel_e;

    typedef struct packed {
        logic              valid;
        logic [6:0]        pad_hi;
        logic [CHAN_W-1:0] chan;
        logic [7:0]        pad_lo;
        logic [CODE_W-1:0] code;
    } entry_t;

    typedef struct packed {
        logic              vld;
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } post_t;

    typedef struct packed {
        logic written;
        logic ovf;
    } qres_t;

    function automatic entry_t make_entry(logic [CHAN_W-1:0] chan, logic [CODE_W-1:0] code);
        entry_t e;
        e        = '0;
        e.valid  = 1'b1;
        e.chan   = chan;
        e.code   = code;
        return e;
    endfunction

    function automatic int ovf_pos(int q);
        return (q == TXQ_ID) ? TQOV_BIT : 2 * q;
    endfunction

    function automatic int new_pos(int q);
        return (q == TXQ_ID) ? TINT_BIT : 2 * q + 1;
    endfunction

endpackage

// File: rtl/irqq_table.sv
module irqq_table
    import irqq_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int NQ     = NUM_Q,
    localparam int IDX_W = $clog2(QDEPTH),
    localparam int QS_W  = $clog2(NQ)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  post_t  [NQ-1:0]       post_i,
    output qres_t  [NQ-1:0]       res_o,
    input  logic                  clr_en,
    input  logic [QS_W-1:0]       clr_q,
    input  logic [IDX_W-1:0]      clr_idx,
    input  logic [QS_W-1:0]       rd_q,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [ENTRY_W-1:0]    rd_data
);

    localparam int WORDS = NQ * QDEPTH;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(QDEPTH - 1);

    entry_t           mem [WORDS];
    logic [IDX_W-1:0] wptr [NQ];
    logic [NQ-1:0]    slot_busy;

    // occupancy of each queue's current write slot
    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            slot_busy[q]     = mem[q * QDEPTH + int'(wptr[q])].valid;
            res_o[q].written = post_i[q].vld & ~slot_busy[q];
            res_o[q].ovf     = post_i[q].vld &  slot_busy[q];
        end
    end

    always_comb begin
        if (int'(rd_q) < NQ)
            rd_data = mem[int'(rd_q) * QDEPTH + int'(rd_idx)];
        else
            rd_data = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++)
                mem[w] <= '0;
            for (int q = 0; q < NQ; q++)
                wptr[q] <= '0;
        end else begin
            if (clr_en && (int'(clr_q) < NQ))
                mem[int'(clr_q) * QDEPTH + int'(clr_idx)].valid <= 1'b0;
            for (int q = 0; q < NQ; q++) begin
                if (res_o[q].written) begin
                    mem[q * QDEPTH + int'(wptr[q])] <= make_entry(post_i[q].chan, post_i[q].code);
                    wptr[q] <= (wptr[q] == LAST_IDX) ? '0 : wptr[q] + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/irqq_events.sv
module irqq_events
    import irqq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] set_i,
    input  logic             wr_en,
    input  regsel_e          sel,
    input  logic [EVT_W-1:0] wdata,
    output logic [EVT_W-1:0] evt_o,
    output logic [EVT_W-1:0] mask_o,
    output logic             irq_o
);

    logic [EVT_W-1:0] clr_vec;

    assign clr_vec = (wr_en && sel == SEL_EVT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_o  <= '0;
            mask_o <= '0;
        end else begin
            evt_o <= ((evt_o & ~clr_vec) | set_i) & EVT_USED;
            if (wr_en && sel == SEL_MASK)
                mask_o <= wdata & EVT_USED;
        end
    end

    assign irq_o = |(evt_o & mask_o);

endmodule

// File: rtl/irq_queue_ctrl.sv
module irq_queue_ctrl
    import irqq_pkg::*;
#(
    parameter int QDEPTH = 8,
    localparam int IDX_W = $clog2(QDEPTH),
    localparam int QS_W  = $clog2(NUM_Q),
    localparam int RQ_W  = $clog2(NUM_RXQ)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_post_vld,
    input  logic [RQ_W-1:0]     rx_post_q,
    input  logic [CHAN_W-1:0]   rx_post_chan,
    input  logic [CODE_W-1:0]   rx_post_code,
    input  logic                tx_post_vld,
    input  logic [CHAN_W-1:0]   tx_post_chan,
    input  logic [CODE_W-1:0]   tx_post_code,
    input  logic                gun_strobe,
    input  logic                gov_strobe,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [EVT_W-1:0]    reg_wdata,
    output logic [EVT_W-1:0]    evt_status,
    output logic [EVT_W-1:0]    mask_status,
    input  logic                ent_clr,
    input  logic [QS_W-1:0]     ent_clr_q,
    input  logic [IDX_W-1:0]    ent_clr_idx,
    input  logic [QS_W-1:0]     ent_rd_q,
    input  logic [IDX_W-1:0]    ent_rd_idx,
    output logic [ENTRY_W-1:0]  ent_rd_data,
    output logic                irq
);

    post_t [NUM_Q-1:0] posts;
    qres_t [NUM_Q-1:0] results;
    logic  [EVT_W-1:0] set_vec;

    // receive posts steer to one of the receive queues; transmit to its own
    genvar gq;
    generate
        for (gq = 0; gq < NUM_RXQ; gq++) begin : g_rxsteer
            assign posts[gq].vld  = rx_post_vld && (int'(rx_post_q) == gq);
            assign posts[gq].chan = rx_post_chan;
            assign posts[gq].code = rx_post_code;
        end
    endgenerate

    assign posts[TXQ_ID].vld  = tx_post_vld;
    assign posts[TXQ_ID].chan = tx_post_chan;
    assign posts[TXQ_ID].code = tx_post_code;

    irqq_table #(.QDEPTH(QDEPTH), .NQ(NUM_Q)) u_table (
        .clk     (clk),
        .rst     (rst),
        .post_i  (posts),
        .res_o   (results),
        .clr_en  (ent_clr),
        .clr_q   (ent_clr_q),
        .clr_idx (ent_clr_idx),
        .rd_q    (ent_rd_q),
        .rd_idx  (ent_rd_idx),
        .rd_data (ent_rd_data)
    );

    always_comb begin
        set_vec = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            set_vec[ovf_pos(q)] = results[q].ovf;
            set_vec[new_pos(q)] = results[q].written;
        end
        set_vec[GUN_BIT] = gun_strobe;
        set_vec[GOV_BIT] = gov_strobe;
    end

    irqq_events u_events (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .wr_en  (reg_wr),
        .sel    (regsel_e'(reg_sel)),
        .wdata  (reg_wdata),
        .evt_o  (evt_status),
        .mask_o (mask_status),
        .irq_o  (irq)
    );

endmodule

// File: rtl/irqq_checker.sv
module irqq_checker
    import irqq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rx_post_vld,
    input logic [1:0]       rx_post_q,
    input logic             tx_post_vld,
    input logic             gun_strobe,
    input logic             gov_strobe,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [EVT_W-1:0] evt_status,
    input logic [EVT_W-1:0] mask_status,
    input logic             irq
);

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_status[11:8] == 4'h0) && (mask_status[11:8] == 4'h0));

    // R6
    sticky_evt_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && !reg_sel) |=> ((evt_status & $past(evt_status)) == $past(evt_status)));

    // R5
    gun_set_chk: assert property (@(posedge clk) disable iff (rst)
        gun_strobe |=> evt_status[GUN_BIT]);

    // R5
    gov_set_chk: assert property (@(posedge clk) disable iff (rst)
        gov_strobe |=> evt_status[GOV_BIT]);

    // R4
    rx_post_evt_chk: assert property (@(posedge clk) disable iff (rst)
        rx_post_vld |=> (evt_status[{$past(rx_post_q), 1'b1}] || evt_status[{$past(rx_post_q), 1'b0}]));

    // R4
    tx_post_evt_chk: assert property (@(posedge clk) disable iff (rst)
        tx_post_vld |=> (evt_status[TINT_BIT] || evt_status[TQOV_BIT]));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_status == '0) |-> !irq);

    // R8
    event_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_status == '0) |-> !irq);

endmodule

bind irq_queue_ctrl irqq_checker u_chk (.*);

// File: tb/irq_queue_ctrl_tb.sv
module irq_queue_ctrl_tb;
    import irqq_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_post_vld;
    logic [1:0]  rx_post_q;
    logic [7:0]  rx_post_chan, rx_post_code;
    logic        tx_post_vld;
    logic [7:0]  tx_post_chan, tx_post_code;
    logic        gun_strobe, gov_strobe;
    logic        reg_wr, reg_sel;
    logic [15:0] reg_wdata;
    logic [15:0] evt_status, mask_status;
    logic        ent_clr;
    logic [2:0]  ent_clr_q, ent_clr_idx, ent_rd_q, ent_rd_idx;
    logic [31:0] ent_rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    irq_queue_ctrl u_dut (.*);

    function automatic logic [31:0] exp_word(logic [7:0] ch, logic [7:0] cd);
        return {1'b1, 7'd0, ch, 8'd0, cd};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic read_ent(input logic [2:0] q, input logic [2:0] idx, output logic [31:0] d);
        ent_rd_q   = q;
        ent_rd_idx = idx;
        #1;
        d = ent_rd_data;
    endtask

    task automatic idle_inputs();
        rx_post_vld = 0; rx_post_q = 0; rx_post_chan = 0; rx_post_code = 0;
        tx_post_vld = 0; tx_post_chan = 0; tx_post_code = 0;
        gun_strobe = 0; gov_strobe = 0;
        reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        ent_clr = 0; ent_clr_q = 0; ent_clr_idx = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic post_rx(input logic [1:0] q, input logic [7:0] ch, input logic [7:0] cd);
        rx_post_vld = 1; rx_post_q = q; rx_post_chan = ch; rx_post_code = cd;
        @(negedge clk);
        rx_post_vld = 0;
    endtask

    task automatic post_tx(input logic [7:0] ch, input logic [7:0] cd);
        tx_post_vld = 1; tx_post_chan = ch; tx_post_code = cd;
        @(negedge clk);
        tx_post_vld = 0;
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic clear_ent(input logic [2:0] q, input logic [2:0] idx);
        ent_clr = 1; ent_clr_q = q; ent_clr_idx = idx;
        @(negedge clk);
        ent_clr = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R6 reset evt", 32'(evt_status), 32'h0);
        check("R7 reset mask", 32'(mask_status), 32'h0);
        check("R8 reset irq", 32'(irq), 32'h0);
        read_ent(3'd4, 3'd0, d);
        check("R1 reset entry", d, 32'h0);
    endtask

    task automatic t_rx_post_mask();
        logic [31:0] d;
        do_reset();
        post_rx(2'd1, 8'h21, 8'h05);
        read_ent(3'd1, 3'd0, d);
        check("R1 rx entry word", d, 32'h8021_0005);
        check("R4 RINT1 bit3", 32'(evt_status), 32'h0008);
        read_ent(3'd4, 3'd0, d);
        check("R4 tx queue untouched", d, 32'h0);
        check("R8 irq masked", 32'(irq), 32'h0);
        reg_write(1'b1, 16'h0008);
        check("R7 mask load", 32'(mask_status), 32'h0008);
        check("R8 irq unmasked", 32'(irq), 32'h1);
        reg_write(1'b0, 16'h0008);
        check("R6 w1c clears", 32'(evt_status), 32'h0);
        check("R8 irq after clear", 32'(irq), 32'h0);
        post_rx(2'd1, 8'h22, 8'h06);
        read_ent(3'd1, 3'd1, d);
        check("R2 advance to slot1", d, 32'h8022_0006);
    endtask

    task automatic t_tx_fill_wrap();
        logic [31:0] d;
        do_reset();
        for (int i = 0; i < 8; i++)
            post_tx(8'(i + 16), 8'(i));
        for (int i = 0; i < 8; i++) begin
            read_ent(3'd4, 3'(i), d);
            check("R1 tx fill entry", d, exp_word(8'(i + 16), 8'(i)));
        end
        check("R4 TINT only", 32'(evt_status), 32'h2000);
        post_tx(8'hAA, 8'h55);
        check("R3 TQOV set", 32'(evt_status), 32'h3000);
        read_ent(3'd4, 3'd0, d);
        check("R3 slot kept", d, exp_word(8'h10, 8'h00));
        read_ent(3'd0, 3'd0, d);
        check("R4 rx queue untouched", d, 32'h0);
        clear_ent(3'd4, 3'd0);
        read_ent(3'd4, 3'd0, d);
        check("R9 valid cleared", d, 32'h0010_0000);
        post_tx(8'h77, 8'h33);
        read_ent(3'd4, 3'd0, d);
        check("R2 wrap to slot0", d, 32'h8077_0033);
    endtask

    task automatic t_set_vs_clear();
        do_reset();
        post_rx(2'd2, 8'h01, 8'h01);
        check("R4 RINT2 bit5", 32'(evt_status), 32'h0020);
        gun_strobe = 1;
        @(negedge clk);
        gun_strobe = 0;
        reg_wr = 1; reg_sel = 0; reg_wdata = 16'h0020;
        rx_post_vld = 1; rx_post_q = 2'd2; rx_post_chan = 8'h02; rx_post_code = 8'h02;
        @(negedge clk);
        reg_wr = 0; rx_post_vld = 0;
        check("R6 set wins over clear", 32'(evt_status), 32'h4020);
        reg_write(1'b0, 16'h0001);
        check("R6 zero bits untouched", 32'(evt_status), 32'h4020);
    endtask

    task automatic t_gun_gov();
        do_reset();
        gun_strobe = 1;
        @(negedge clk);
        gun_strobe = 0;
        @(negedge clk);
        @(negedge clk);
        check("R5 GUN sticky", 32'(evt_status), 32'h4000);
        gov_strobe = 1;
        @(negedge clk);
        gov_strobe = 0;
        check("R5 GOV set", 32'(evt_status), 32'hC000);
        reg_write(1'b1, 16'h8000);
        check("R8 irq from GOV", 32'(irq), 32'h1);
        reg_write(1'b0, 16'h4000);
        check("R5 GUN cleared only", 32'(evt_status), 32'h8000);
        reg_write(1'b0, 16'h8000);
        check("R8 irq drops", 32'(irq), 32'h0);
    endtask

    task automatic t_reserved();
        do_reset();
        reg_write(1'b1, 16'hFFFF);
        check("R7 mask reserved zero", 32'(mask_status), 32'hF0FF);
        reg_write(1'b0, 16'hFFFF);
        check("R7 evt reserved zero", 32'(evt_status), 32'h0);
    endtask

    task automatic t_dual_post();
        logic [31:0] d;
        do_reset();
        rx_post_vld = 1; rx_post_q = 2'd3; rx_post_chan = 8'h33; rx_post_code = 8'h03;
        tx_post_vld = 1; tx_post_chan = 8'h44; tx_post_code = 8'h04;
        @(negedge clk);
        rx_post_vld = 0; tx_post_vld = 0;
        read_ent(3'd3, 3'd0, d);
        check("R10 rx part", d, 32'h8033_0003);
        read_ent(3'd4, 3'd0, d);
        check("R10 tx part", d, 32'h8044_0004);
        check("R10 both events", 32'(evt_status), 32'h2080);
    endtask

    task automatic t_clear_race();
        logic [31:0] d;
        do_reset();
        for (int i = 0; i < 8; i++)
            post_rx(2'd0, 8'(i), 8'h0E);
        check("R4 RINT0 only", 32'(evt_status), 32'h0002);
        ent_clr = 1; ent_clr_q = 3'd0; ent_clr_idx = 3'd0;
        rx_post_vld = 1; rx_post_q = 2'd0; rx_post_chan = 8'hEE; rx_post_code = 8'hEE;
        @(negedge clk);
        ent_clr = 0; rx_post_vld = 0;
        check("R9 race overflows", 32'(evt_status), 32'h0003);
        read_ent(3'd0, 3'd0, d);
        check("R9 race slot freed", d, 32'h0000_000E);
        post_rx(2'd0, 8'h99, 8'h01);
        read_ent(3'd0, 3'd0, d);
        check("R9 later post lands", d, 32'h8099_0001);
    endtask

    task automatic t_drain();
        logic [31:0] d;
        int n;
        do_reset();
        for (int i = 0; i < 3; i++)
            post_rx(2'd2, 8'(i + 1), 8'h07);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            read_ent(3'd2, 3'(i), d);
            if (!d[31]) break;
            check("R1 drain order", 32'(d[23:16]), 32'(i + 1));
            clear_ent(3'd2, 3'(i));
            n++;
        end
        check("R1 drained count", 32'(n), 32'd3);
        read_ent(3'd2, 3'd0, d);
        check("R9 drained slot free", 32'(d[31]), 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ent_rd_q = 0;
        ent_rd_idx = 0;
        idle_inputs();
        t_reset();
        t_rx_post_mask();
        t_tx_fill_wrap();
        t_set_vs_clear();
        t_gun_gov();
        t_reserved();
        t_dual_post();
        t_clear_race();
        t_drain();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule